// File: doc/BRIEF.md
# Playback Attenuator with Zero-Cross Gain Update

This block scales a stereo stream of 16-bit two's-complement samples by a shared attenuation setting. A 7-bit code selects the gain. The top code gives unity gain (0 dB), each lower code removes a further 0.75 dB, and code zero mutes the output. The code is turned into a linear Q1.15 multiplier by a lookup table that is filled when the design is elaborated. Each channel's product is rounded and limited back to 16 bits.

A written code first becomes the target. It replaces the active code in one of two ways, chosen by an input. In the immediate way, the next accepted sample already uses the new code. In the zero-cross way, the change waits until both channels have changed sign since the write, so that steps in gain do not cause audible clicks. If a channel never changes sign, a selectable timeout of 1, 2, 4 or 8 time units forces the change. At the default unit of 384 samples, which is 8 ms at 48 kHz, this gives timeouts of 8, 16, 32 and 64 ms. Both channels always switch on the same sample.

Top module: `pbatt_top`

## Requirements
- R1: For codes 1 to 88, the gain is round(32768 * 10^(-0.75*(88-code)/20)) as an unsigned Q1.15 value, so code 88 is exactly 32768 (0 dB).
- R2: Code 0 makes both outputs 0. After reset, the target and active codes are both 0, so the output is muted.
- R3: A written code above 88 is stored as 88.
- R4: Each output equals (sample*gain + 16384) >>> 15, saturated to the signed 16-bit range. It appears on out_l/out_r with out_valid high exactly two clock cycles after the cycle in which in_valid was high.
- R5: With zc_en low, the first sample accepted after a write that changes the code is scaled by the new code.
- R6: With zc_en high, a channel crosses zero when the sign bit (bit 15) of its sample differs from the sign bit of that channel's previous sample. The new code applies from the first sample by which both channels have crossed since the write, and that sample itself uses the new code. Both channels always use the same code.
- R7: With zc_en high, let N = TMO_UNIT * 2^tmo_sel samples. If the crossings have not completed, the N-th sample after the write uses the new code.
- R8: A new write restarts both the crossing tracking and the timeout count.
- R9: The active code changes only on a cycle with in_valid high, and it changes only to the target code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Load wr_code as the new target |
| wr_code | input | 7 | Attenuation code (88 = 0 dB, 0 = mute) |
| zc_en | input | 1 | 1: wait for zero crossings; 0: update on the next sample |
| tmo_sel | input | 2 | Timeout of TMO_UNIT << tmo_sel samples |
| in_valid | input | 1 | A stereo sample is present |
| in_l | input | 16 | Left input sample |
| in_r | input | 16 | Right input sample |
| out_valid | output | 1 | Scaled sample is present |
| out_l | output | 16 | Left scaled sample |
| out_r | output | 16 | Right scaled sample |

## Verification
Every scaled sample is due exactly two clock cycles after its input cycle: one cycle for the registered table read and one for the registered product. The bench drives each sample, waits for two falling edges and then checks out_valid and both channels together. A code change shows up only in the scaling of later samples. For that reason the bench model selects the code for each sample at the moment the sample is sent, and it applies the crossing and timeout rules in the same order as the hardware. The checker also compares out_valid against in_valid delayed by two cycles, counted from reset.

// File: rtl/pbatt_pkg.sv
package pbatt_pkg;
  localparam int CODE_W    = 7;
  localparam int UNITY     = 88;
  localparam int GAIN_W    = 16;
  localparam int GAIN_FRAC = 15;
  localparam int ROM_DEPTH = 1 << CODE_W;

  // Linear Q1.15 gain for one code; codes above unity read as unity.
  function automatic logic [GAIN_W-1:0] gain_for_code(int k);
    int  c;
    real v;
    if (k == 0) return '0;
    c = (k > UNITY) ? UNITY : k;
    v = 32768.0 * $pow(10.0, -(0.75 * real'(UNITY - c)) / 20.0);
    return GAIN_W'(int'(v));
  endfunction
endpackage

// File: rtl/pbatt_gain_rom.sv
module pbatt_gain_rom
  import pbatt_pkg::*;
(
  input  logic              clk,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] code,
  output logic [GAIN_W-1:0] gain
);
  logic [GAIN_W-1:0] rom [0:ROM_DEPTH-1];

  initial begin
    for (int i = 0; i < ROM_DEPTH; i++) rom[i] = gain_for_code(i);
  end

  always_ff @(posedge clk) begin
    if (rd_en) gain <= rom[code];
  end
endmodule

// File: rtl/pbatt_zc_ctrl.sv
module pbatt_zc_ctrl
  import pbatt_pkg::*;
#(
  parameter int TMO_UNIT = 384
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  input  logic              zc_en,
  input  logic [1:0]        tmo_sel,
  input  logic              in_valid,
  input  logic              sign_l,
  input  logic              sign_r,
  output logic [CODE_W-1:0] eff_code,
  output logic [CODE_W-1:0] tgt_q,
  output logic [CODE_W-1:0] act_q
);
  localparam int TMO_MAX = TMO_UNIT * 8;
  localparam int CNT_W   = $clog2(TMO_MAX + 1);

  logic             prev_l, prev_r, seen_l, seen_r;
  logic [CNT_W-1:0] cnt_q, limit, cnt_nx;
  logic             pending, cross_l, cross_r, both, tmo_hit, take;

  always_comb begin
    pending  = (tgt_q != act_q);
    cross_l  = sign_l ^ prev_l;
    cross_r  = sign_r ^ prev_r;
    both     = (seen_l | cross_l) & (seen_r | cross_r);
    limit    = CNT_W'(TMO_UNIT) << tmo_sel;
    cnt_nx   = cnt_q + 1'b1;
    tmo_hit  = (cnt_nx >= limit);
    take     = in_valid & pending & (~zc_en | both | tmo_hit);
    eff_code = take ? tgt_q : act_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q  <= '0;
      act_q  <= '0;
      prev_l <= 1'b0;
      prev_r <= 1'b0;
      seen_l <= 1'b0;
      seen_r <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_en) tgt_q <= (wr_code > CODE_W'(UNITY)) ? CODE_W'(UNITY) : wr_code;
      if (in_valid) begin
        prev_l <= sign_l;
        prev_r <= sign_r;
        if (take) act_q <= tgt_q;
      end
      if (wr_en || take) begin
        seen_l <= 1'b0;
        seen_r <= 1'b0;
        cnt_q  <= '0;
      end else if (in_valid && pending) begin
        seen_l <= seen_l | cross_l;
        seen_r <= seen_r | cross_r;
        cnt_q  <= cnt_nx;
      end
    end
  end
endmodule

// File: rtl/pbatt_scale.sv
module pbatt_scale
  import pbatt_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [GAIN_W-1:0]   gain,
  output logic [SAMPLE_W-1:0] result
);
  localparam int PW = SAMPLE_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] HI = {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = {{(PW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (GAIN_FRAC - 1);

  logic signed [PW-1:0]       prod, shf;
  logic        [SAMPLE_W-1:0] sat;

  always_comb begin
    prod = $signed(sample) * $signed({1'b0, gain});
    shf  = (prod + HALF) >>> GAIN_FRAC;
    if (shf > HI)      sat = HI[SAMPLE_W-1:0];
    else if (shf < LO) sat = LO[SAMPLE_W-1:0];
    else               sat = shf[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)     result <= '0;
    else if (en) result <= sat;
  end
endmodule

// File: rtl/pbatt_top.sv
module pbatt_top
  import pbatt_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int TMO_UNIT = 384
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [CODE_W-1:0]   wr_code,
  input  logic                zc_en,
  input  logic [1:0]          tmo_sel,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_l,
  input  logic [SAMPLE_W-1:0] in_r,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_l,
  output logic [SAMPLE_W-1:0] out_r
);
  localparam int NCH = 2;

  logic [CODE_W-1:0]             eff_code, tgt_code, act_code;
  logic [GAIN_W-1:0]             gain;
  logic                          s1_valid;
  logic [NCH-1:0][SAMPLE_W-1:0]  s1_samp, res;

  pbatt_zc_ctrl #(.TMO_UNIT(TMO_UNIT)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code),
    .zc_en(zc_en), .tmo_sel(tmo_sel), .in_valid(in_valid),
    .sign_l(in_l[SAMPLE_W-1]), .sign_r(in_r[SAMPLE_W-1]),
    .eff_code(eff_code), .tgt_q(tgt_code), .act_q(act_code)
  );

  pbatt_gain_rom u_rom (
    .clk(clk), .rd_en(in_valid), .code(eff_code), .gain(gain)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_samp   <= '0;
      out_valid <= 1'b0;
    end else begin
      s1_valid  <= in_valid;
      out_valid <= s1_valid;
      if (in_valid) s1_samp <= {in_r, in_l};
    end
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    pbatt_scale #(.SAMPLE_W(SAMPLE_W)) u_scale (
      .clk(clk), .rst(rst), .en(s1_valid),
      .sample(s1_samp[ch]), .gain(gain), .result(res[ch])
    );
  end

  assign out_l = res[0];
  assign out_r = res[1];
endmodule

// File: rtl/pbatt_chk.sv
module pbatt_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_l,
  input logic [SAMPLE_W-1:0] in_r,
  input logic                out_valid,
  input logic [SAMPLE_W-1:0] out_l,
  input logic [SAMPLE_W-1:0] out_r,
  input logic [6:0]          act_code,
  input logic [6:0]          tgt_code
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst)            age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (rst)
    (age >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_zero_in_R4: assert property (@(posedge clk) disable iff (rst)
    ((age >= 2'd2) && $past(in_valid, 2) && $past(in_l, 2) == '0 && $past(in_r, 2) == '0)
      |-> (out_l == '0 && out_r == '0));

  assert_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    (tgt_code <= 7'd88) && (act_code <= 7'd88));

  assert_on_sample_R9: assert property (@(posedge clk) disable iff (rst)
    ((age >= 2'd1) && act_code != $past(act_code)) |-> $past(in_valid));

  assert_to_target_R9: assert property (@(posedge clk) disable iff (rst)
    ((age >= 2'd1) && act_code != $past(act_code)) |-> (act_code == $past(tgt_code)));
endmodule

bind pbatt_top pbatt_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
  .out_valid(out_valid), .out_l(out_l), .out_r(out_r),
  .act_code(act_code), .tgt_code(tgt_code)
);

// File: tb/pbatt_top_bench.sv
`timescale 1ns/1ps
module pbatt_top_bench;
  localparam int SW   = 16;
  localparam int UNIT = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [6:0]    wr_code = '0;
  logic          zc_en = 1'b0;
  logic [1:0]    tmo_sel = '0;
  logic          in_valid = 1'b0;
  logic [SW-1:0] in_l = '0, in_r = '0;
  logic          out_valid;
  logic [SW-1:0] out_l, out_r;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  int m_tgt = 0, m_act = 0, m_cnt = 0;
  bit m_pl = 0, m_pr = 0, m_sl = 0, m_sr = 0;

  always #2 clk = ~clk;

  pbatt_top #(.SAMPLE_W(SW), .TMO_UNIT(UNIT)) u_pbatt_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_code(wr_code), .zc_en(zc_en),
    .tmo_sel(tmo_sel), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
    .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
  );

  function automatic int exp_gain(int c);
    if (c == 0) return 0;
    if (c > 88) c = 88;
    return int'(32768.0 * $pow(10.0, -0.0375 * real'(88 - c)));
  endfunction

  function automatic logic [SW-1:0] exp_out(logic [SW-1:0] s, int g);
    longint p;
    p = (longint'($signed(s)) * longint'(g) + 16384) >>> 15;
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return SW'(p);
  endfunction

  task automatic write_code(int c);
    @(negedge clk);
    wr_en = 1'b1; wr_code = 7'(c);
    @(negedge clk);
    wr_en = 1'b0;
    m_tgt = (c > 88) ? 88 : c;
    m_sl = 0; m_sr = 0; m_cnt = 0;
  endtask

  // Sends one sample; checks the output two cycles later against the model.
  task automatic send(logic [SW-1:0] l, logic [SW-1:0] r, string req);
    bit cl, cr, pend, take, hit;
    int code, lim;
    logic [SW-1:0] el, er;
    pend = (m_tgt != m_act);
    cl   = l[SW-1] ^ m_pl;
    cr   = r[SW-1] ^ m_pr;
    lim  = UNIT << tmo_sel;
    hit  = (m_cnt + 1) >= lim;
    take = pend && (!zc_en || ((m_sl | cl) && (m_sr | cr)) || hit);
    code = take ? m_tgt : m_act;
    if (take) begin
      m_act = m_tgt; m_sl = 0; m_sr = 0; m_cnt = 0;
    end else if (pend) begin
      m_sl = m_sl | cl; m_sr = m_sr | cr; m_cnt++;
    end
    m_pl = l[SW-1]; m_pr = r[SW-1];
    el = exp_out(l, exp_gain(code));
    er = exp_out(r, exp_gain(code));
    in_valid = 1'b1; in_l = l; in_r = r;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b1 || out_l !== el || out_r !== er) begin
      errors++;
      $display("FAIL %s: valid=%b l=%h r=%h expected valid=1 l=%h r=%h (code %0d)",
               req, out_valid, out_l, out_r, el, er, code);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0451));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_l !== '0 || out_r !== '0) begin
      errors++;
      $display("FAIL R2 reset: valid=%b l=%h r=%h expected 0 0 0", out_valid, out_l, out_r);
    end
    send(16'h1234, 16'hC000, "R2 reset mute");

    // R5 immediate update, R1 unity, R4 rounding limits
    zc_en = 0;
    write_code(88);
    send(16'h7FFF, 16'h8000, "R5 R1 unity");
    send(16'h0001, 16'hFFFF, "R4 small");
    write_code(1);
    send(16'h7FFF, 16'h8000, "R1 code1 -65.25dB");
    write_code(0);
    send(16'h7FFF, 16'h8000, "R2 mute code");
    write_code(127);
    send(16'h4000, 16'hC123, "R3 clamp");
    write_code(40);
    send(16'h3333, 16'hA5A5, "R1 R5 code40");

    // R6 zero-cross: only left crosses, then right crosses
    zc_en = 1; tmo_sel = 3;
    send(16'h1000, 16'h1000, "R6 setup");
    write_code(70);
    send(16'h1000, 16'h2000, "R6 no crossing");
    send(16'hF000, 16'h2000, "R6 left only");
    send(16'hF000, 16'h2000, "R6 still waiting");
    send(16'hF000, 16'hE000, "R6 right last");
    send(16'h1000, 16'h1000, "R6 after update");

    // R7 timeout with tmo_sel=1 (8 samples)
    tmo_sel = 1;
    write_code(20);
    for (int i = 0; i < 9; i++) send(16'h2000, 16'h2000, "R7 timeout");

    // R8 rewrite restarts tracking
    tmo_sel = 0;
    write_code(60);
    send(16'hE000, 16'h2000, "R8 left cross");
    write_code(50);
    send(16'hE000, 16'hE000, "R8 right cross only");
    send(16'h2000, 16'hE000, "R8 left cross again");
    send(16'h2000, 16'hE000, "R8 steady");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom_range(0, 9));
      if (sel == 0) write_code(int'($urandom_range(0, 127)));
      else if (sel == 1) begin
        zc_en = 1'($urandom_range(0, 1));
        tmo_sel = 2'($urandom_range(0, 3));
      end
      send(SW'($urandom), ($urandom_range(0, 3) == 0) ? SW'($urandom) : in_r,
           "R4 R5 R6 R7 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule